// File: doc/BRIEF.md
# Serial Register Access Port

This block is the slave end of a four-wire serial control link. An external host drives a serial clock, an active-low chip select and a serial data line, and gets a serial data line with its own output enable back. Through this link the host reads and writes a bank of 256 eight-bit registers held inside the block.

Each transfer happens inside one low window of chip select. The host first sends a start bit, then one bit that picks read or write, then the register address, most significant bit first. On a write, one or more data bytes follow. Each complete byte lands in the addressed register, and the address then steps to the next register. On a read, the block shifts the addressed byte out, most significant bit first. If the host keeps clocking after the byte is done, the block keeps sending its last bit. Inputs are sampled on rising serial clock edges. The output changes on falling edges, so the host can sample it on the next rising edge.

Top module: `sri_port`

## Requirements
- R1: While rst_ni is low, every register is cleared to 0x00. A read of any address after reset returns 0x00.
- R2: A frame sent while cs_ni is low is made of: a start bit of 1, then an opcode bit (0 = write, 1 = read), then an 8-bit address MSB first. For a write, 8-bit data bytes follow, MSB first. A written byte reads back unchanged at its address.
- R3: When several data bytes follow the address in one write frame, byte k is stored at address + k, and the address wraps from 0xFF to 0x00.
- R4: A data byte with fewer than 8 bits received when cs_ni rises is discarded. Its target register keeps its old value, and the bytes completed before it stay written.
- R5: On a read, the data bits appear on sdo_o MSB first. The first bit is valid at the rising edge right after the last address bit. Every rising edge after the 8th data bit sees the byte's LSB repeated.
- R6: sdo_en_o is low while cs_ni is high, during the start, opcode and address bits of a read, and during the whole of a write frame.
- R7: A rise and a new fall of cs_ni abandons any frame in progress. The frame that follows is decoded from its own start bit.
- R8: If the first bit after cs_ni falls is 0, the rest of that chip-select window writes no register and never enables sdo_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Serial clock from the host |
| rst_ni | input | 1 | Asynchronous active-low system reset, clears all registers |
| cs_ni | input | 1 | Active-low chip select; high resets the frame logic |
| sdi_i | input | 1 | Serial data in, sampled on sclk_i rising edge |
| sdo_o | output | 1 | Serial data out, updated on sclk_i falling edge |
| sdo_en_o | output | 1 | Output enable for sdo_o; the pad is tri-stated when low |

## Verification
Checked on every rising edge: the output enable is off whenever chip select is high and is on only during the data phase of a read frame. No register write happens while chip select is high. Between two byte writes in one frame, the write address steps by exactly one. Other properties are only visible from a whole transfer, so the bench scenarios cover them: correct bit order, the wrap at the top of the address space, dropping of a partial byte, the repeated LSB on an over-clocked read, recovery after an aborted frame, and the silence that follows a bad start bit.

// File: rtl/sri_pkg.sv
package sri_pkg;
  typedef enum logic [2:0] {
    PH_START,
    PH_OPCODE,
    PH_ADDR,
    PH_DATA,
    PH_DEAD
  } phase_e;
endpackage

// File: rtl/sri_frame.sv
module sri_frame
  import sri_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              sclk_i,
  input  logic              frm_rst_ni,
  input  logic              sdi_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_act_o,
  output logic [CNT_W-1:0]  rd_cnt_o
);
  phase_e            phase_q;
  logic              is_read_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-2:0] shift_q;

  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] DATA_FULL = CNT_W'(DATA_W);

  always_ff @(posedge sclk_i or negedge frm_rst_ni) begin
    if (!frm_rst_ni) begin
      phase_q   <= PH_START;
      is_read_q <= 1'b0;
      cnt_q     <= '0;
      addr_q    <= '0;
      shift_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_START:  phase_q <= sdi_i ? PH_OPCODE : PH_DEAD;
        PH_OPCODE: begin
          is_read_q <= sdi_i;
          cnt_q     <= '0;
          phase_q   <= PH_ADDR;
        end
        PH_ADDR: begin
          addr_q <= {addr_q[ADDR_W-2:0], sdi_i};
          if (cnt_q == ADDR_LAST) begin
            cnt_q   <= '0;
            phase_q <= PH_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DATA: begin
          if (is_read_q) begin
            // saturate so the LSB keeps being selected
            if (cnt_q != DATA_FULL) cnt_q <= cnt_q + 1'b1;
          end else begin
            shift_q <= {shift_q[DATA_W-3:0], sdi_i};
            if (cnt_q == DATA_LAST) begin
              cnt_q  <= '0;
              addr_q <= addr_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: phase_q <= PH_DEAD;
      endcase
    end
  end

  assign wr_stb_o  = (phase_q == PH_DATA) && !is_read_q && (cnt_q == DATA_LAST);
  assign wr_data_o = {shift_q, sdi_i};
  assign addr_o    = addr_q;
  assign rd_act_o  = (phase_q == PH_DATA) && is_read_q;
  assign rd_cnt_o  = cnt_q;
endmodule

// File: rtl/sri_regbank.sv
module sri_regbank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_stb_i) begin
      mem_q[addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[addr_i];
endmodule

// File: rtl/sri_sdo_drv.sv
module sri_sdo_drv #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              sclk_i,
  input  logic              frm_rst_ni,
  input  logic              rd_act_i,
  input  logic [CNT_W-1:0]  rd_cnt_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sdo_o,
  output logic              sdo_en_o
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0] sel;
  logic             sdo_q;
  logic             en_q;

  always_comb begin
    if (rd_cnt_i >= CNT_W'(DATA_W)) sel = '0;
    else sel = IDX_W'(DATA_W - 1 - int'(rd_cnt_i));
  end

  // launch on the falling edge, host samples on the next rising edge
  always_ff @(negedge sclk_i or negedge frm_rst_ni) begin
    if (!frm_rst_ni) begin
      sdo_q <= 1'b0;
      en_q  <= 1'b0;
    end else if (rd_act_i) begin
      sdo_q <= rd_data_i[sel];
      en_q  <= 1'b1;
    end
  end

  assign sdo_o    = sdo_q;
  assign sdo_en_o = en_q;
endmodule

// File: rtl/sri_port.sv
module sri_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic sclk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_en_o
);
  localparam int MAX_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W = $clog2(MAX_W) + 1;

  logic              frm_rst_n;
  logic              wr_stb;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic              rd_act;
  logic [CNT_W-1:0]  rd_cnt;

  // chip select high holds the frame logic in reset
  assign frm_rst_n = rst_ni & ~cs_ni;

  sri_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_frame (
    .sclk_i    (sclk_i),
    .frm_rst_ni(frm_rst_n),
    .sdi_i     (sdi_i),
    .wr_stb_o  (wr_stb),
    .addr_o    (cur_addr),
    .wr_data_o (wr_data),
    .rd_act_o  (rd_act),
    .rd_cnt_o  (rd_cnt)
  );

  sri_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .sclk_i   (sclk_i),
    .rst_ni   (rst_ni),
    .wr_stb_i (wr_stb),
    .addr_i   (cur_addr),
    .wr_data_i(wr_data),
    .rd_data_o(rd_data)
  );

  sri_sdo_drv #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_drv (
    .sclk_i    (sclk_i),
    .frm_rst_ni(frm_rst_n),
    .rd_act_i  (rd_act),
    .rd_cnt_i  (rd_cnt),
    .rd_data_i (rd_data),
    .sdo_o     (sdo_o),
    .sdo_en_o  (sdo_en_o)
  );
endmodule

// File: rtl/sri_port_chk.sv
module sri_port_chk #(
  parameter int ADDR_W = 8
) (
  input logic              sclk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              sdo_en_o,
  input logic              wr_stb,
  input logic              rd_act,
  input logic [ADDR_W-1:0] cur_addr
);
  a_r6_oe_off_cs_high: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    cs_ni |-> !sdo_en_o);

  a_r6_oe_only_read_data: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    sdo_en_o |-> rd_act);

  a_r7_no_write_cs_high: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    cs_ni |-> !wr_stb);

  a_r3_addr_steps: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (wr_stb && !cs_ni) |=> (cs_ni || cur_addr == $past(cur_addr) + ADDR_W'(1)));
endmodule

bind sri_port sri_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .sclk_i  (sclk_i),
  .rst_ni  (rst_ni),
  .cs_ni   (cs_ni),
  .sdo_en_o(sdo_en_o),
  .wr_stb  (wr_stb),
  .rd_act  (rd_act),
  .cur_addr(cur_addr)
);

// File: tb/sim_sri_port.sv
`timescale 1ns/1ps
module sim_sri_port;
  logic clk = 1'b0;
  logic rst_ni, cs_ni, sdi_i;
  logic sdo_o, sdo_en_o;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  sri_port u0 (
    .sclk_i  (clk),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .sdi_i   (sdi_i),
    .sdo_o   (sdo_o),
    .sdo_en_o(sdo_en_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one serial bit: drive, rising edge, sample, return to falling edge
  task automatic bit_xfer(input logic b, output logic s, output logic oe);
    sdi_i = b;
    @(posedge clk);
    #1;
    s  = sdo_o;
    oe = sdo_en_o;
    @(negedge clk);
  endtask

  task automatic cs_low();
    @(negedge clk);
    cs_ni = 1'b0;
  endtask

  task automatic cs_high();
    cs_ni = 1'b1;
    sdi_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // bytes packed MSB-first in data[31:0]; total data bits = 8*nbytes + extra
  task automatic write_frame(input logic sb, input logic [7:0] addr,
                             input logic [31:0] data, input int nbits,
                             output bit oe_seen);
    logic s, oe;
    oe_seen = 1'b0;
    cs_low();
    bit_xfer(sb, s, oe);   oe_seen |= oe;
    bit_xfer(1'b0, s, oe); oe_seen |= oe;
    for (int i = 7; i >= 0; i--) begin bit_xfer(addr[i], s, oe); oe_seen |= oe; end
    for (int k = 0; k < nbits; k++) begin bit_xfer(data[31-k], s, oe); oe_seen |= oe; end
    cs_high();
  endtask

  task automatic read_frame(input logic [7:0] addr, input int extra,
                            output logic [7:0] data, output bit oe_early,
                            output bit oe_miss, output int lsb_bad);
    logic s, oe;
    oe_early = 1'b0; oe_miss = 1'b0; lsb_bad = 0;
    cs_low();
    bit_xfer(1'b1, s, oe); oe_early |= oe;
    bit_xfer(1'b1, s, oe); oe_early |= oe;
    for (int i = 7; i >= 0; i--) begin bit_xfer(addr[i], s, oe); oe_early |= oe; end
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b0, s, oe);
      data[i] = s;
      if (!oe) oe_miss = 1'b1;
    end
    for (int k = 0; k < extra; k++) begin
      bit_xfer(1'b0, s, oe);
      if (s !== data[0] || !oe) lsb_bad++;
    end
    cs_high();
  endtask

  task automatic expect_reg(input logic [7:0] addr, input logic [7:0] exp, input string req);
    logic [7:0] d; bit e, m; int lb;
    read_frame(addr, 0, d, e, m, lb);
    chk(d === exp, req, d, exp);
  endtask

  task automatic t_reset();
    chk(sdo_en_o === 1'b0, "R6 oe after reset", sdo_en_o, 0);
    expect_reg(8'h00, 8'h00, "R1 reg 0x00");
    expect_reg(8'h5A, 8'h00, "R1 reg 0x5A");
    expect_reg(8'hFF, 8'h00, "R1 reg 0xFF");
  endtask

  task automatic t_write_read();
    bit oe;
    write_frame(1'b1, 8'h12, 32'hA500_0000, 8, oe);
    chk(!oe, "R6 oe in write frame", oe, 0);
    write_frame(1'b1, 8'h34, 32'h3C00_0000, 8, oe);
    write_frame(1'b1, 8'h80, 32'h0100_0000, 8, oe);
    expect_reg(8'h12, 8'hA5, "R2 addr 0x12");
    expect_reg(8'h34, 8'h3C, "R2 addr 0x34");
    expect_reg(8'h80, 8'h01, "R2 addr 0x80");
    expect_reg(8'h01, 8'h00, "R2 bit order, 0x80 not 0x01");
  endtask

  task automatic t_seq_wrap();
    bit oe;
    write_frame(1'b1, 8'hFE, 32'h1122_3300, 24, oe);
    expect_reg(8'hFE, 8'h11, "R3 first byte");
    expect_reg(8'hFF, 8'h22, "R3 second byte");
    expect_reg(8'h00, 8'h33, "R3 wrap to 0x00");
    expect_reg(8'h01, 8'h00, "R3 no fourth byte");
  endtask

  task automatic t_partial();
    bit oe;
    write_frame(1'b1, 8'h40, 32'h77FF_0000, 13, oe);
    expect_reg(8'h40, 8'h77, "R4 completed byte kept");
    expect_reg(8'h41, 8'h00, "R4 partial byte dropped");
  endtask

  task automatic t_overclock();
    logic [7:0] d; bit e, m; int lb;
    read_frame(8'h12, 6, d, e, m, lb);
    chk(d === 8'hA5, "R5 read data", d, 8'hA5);
    chk(lb == 0, "R5 LSB=1 repeated", lb, 0);
    chk(!e, "R6 oe off in cmd/addr", e, 0);
    chk(!m, "R6 oe on in data", m, 0);
    read_frame(8'h34, 5, d, e, m, lb);
    chk(d === 8'h3C && lb == 0, "R5 LSB=0 repeated", lb, 0);
  endtask

  task automatic t_abort();
    logic s, oe;
    bit oe_w;
    logic [7:0] d; bit e, m; int lb;
    cs_low();
    bit_xfer(1'b1, s, oe); bit_xfer(1'b0, s, oe);
    for (int i = 7; i >= 0; i--) bit_xfer(logic'((8'h50 >> i) & 1), s, oe);
    for (int i = 0; i < 4; i++) bit_xfer(1'b1, s, oe);
    cs_high();
    write_frame(1'b1, 8'h51, 32'h9900_0000, 8, oe_w);
    expect_reg(8'h50, 8'h00, "R7 aborted byte");
    expect_reg(8'h51, 8'h99, "R7 next frame");
    // abort inside the address phase, then read
    cs_low();
    bit_xfer(1'b1, s, oe); bit_xfer(1'b0, s, oe); bit_xfer(1'b1, s, oe);
    cs_high();
    read_frame(8'h51, 0, d, e, m, lb);
    chk(d === 8'h99, "R7 read after address abort", d, 8'h99);
  endtask

  task automatic t_bad_start();
    bit oe;
    write_frame(1'b0, 8'h12, 32'hFFFF_FF00, 24, oe);
    chk(!oe, "R8 oe stays off", oe, 0);
    expect_reg(8'h12, 8'hA5, "R8 reg 0x12 untouched");
    expect_reg(8'h13, 8'h00, "R8 reg 0x13 untouched");
  endtask

  initial begin
    rst_ni = 1'b0; cs_ni = 1'b1; sdi_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_seq_wrap();
    t_partial();
    t_overclock();
    t_abort();
    t_bad_start();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(100_000 * 10);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule